// File: doc/BRIEF.md
# Reciprocal Frequency Counter

This block measures the rate of an external digital signal over a wide range of frequencies without any range switching. It keeps two counters side by side: a time counter that advances on a prescaled tick derived from the system clock, and a cycle counter that advances on each rising edge of the input. Both are driven from a single synchronizer and edge detector, so both see exactly the same input edge.

Software arms a measurement. The next synchronized rising edge then copies both counters into capture registers in the same clock cycle, and sets a ready flag. Each reading therefore spans a whole number of input cycles. Software divides cycles by time to obtain frequency; that division is outside the block.

An automatic mode captures on every M-th input edge instead of waiting for software. A second mode bit chooses whether the counters restart at zero on each capture or keep running, in which case software subtracts successive readings.

Top module: `recip_freq_counter`

## Requirements
- R1: After reset `ready` is 0 and `capTime` and `capCycles` are 0.
- R2: `sigIn` passes through one two-stage synchronizer. A rising edge of the synchronized signal makes a one-cycle edge pulse that feeds both counters. The cycle counter advances by one per input rising edge.
- R3: The time counter advances once every D system clocks, where D equals `prescale`. A `prescale` of 0 or 1 gives D = 1.
- R4: With `autoMode` = 0, a one-cycle `armReq` pulse arms the block. The first edge pulse after arming, with `ready` low, captures both counters once. No further capture happens until the block is armed again.
- R5: A capture sets `ready`, and a `readyClr` pulse clears it. While `ready` is 1, `capTime` and `capCycles` hold their values and no capture takes place. An arm given during that time waits for `ready` to clear.
- R6: With `clearOnCapture` = 1, the counters and the prescaler restart at zero on each capture. If k input edges occur with period P clocks, the next reading is `capCycles` = k, counting the capturing edge, and `capTime` = floor(k·P/D).
- R7: With `clearOnCapture` = 0, the counters run freely and wrap. The difference between two successive readings gives the edges and ticks between the two capture edges.
- R8: With `autoMode` = 1, a capture happens on every M-th edge pulse, where M equals `cycleLimit`, and a value of 0 means 1. `armReq` has no effect in this mode. A window that ends while `ready` is 1 is dropped, and its edges fall into the next reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Asynchronous signal being measured |
| prescale | input | PRE_W | Time tick divisor D (0 or 1 gives divide by one) |
| cycleLimit | input | CNT_W | Edges per automatic window M (0 treated as 1) |
| autoMode | input | 1 | 1: capture every M edges; 0: capture on arm |
| clearOnCapture | input | 1 | 1: counters restart on capture; 0: free-running |
| armReq | input | 1 | One-cycle pulse that arms a single capture |
| readyClr | input | 1 | One-cycle pulse that clears `ready` |
| capTime | output | CNT_W | Captured time tick count |
| capCycles | output | CNT_W | Captured input edge count |
| ready | output | 1 | A capture is held and has not been cleared |

## Verification
The bench goes after the boundaries of the capture window. A re-arm right after a capture must yield exactly one cycle and P/D ticks. A design that lost the tick or the edge from the capture cycle, or that failed to restart the prescaler, would be off by one. Prescale values of 0 and 1, and divisors that do not divide the period, expose a wrong divide rule. A one-shot that re-fires, or captures that overwrite a held reading, show up as `ready` rising again without an arm or as changed values while `ready` is high. Automatic windows are checked for exact spacing and for the dropped-window case, where a design that kept the window but lost its edges would report a count that is not a multiple of M.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic capture;      // copy both counters into the capture registers
    logic clearCounts;  // restart counters and prescaler at zero
  } rfcStrobe_t;
endpackage

// File: rtl/rfc_sync_edge.sv
module rfc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic edgePulse
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rstN) sh <= '0;
    else       sh <= {sh[STAGES-1:0], sigIn};
  end

  assign edgePulse = sh[STAGES-1] & ~sh[STAGES];

  // R2: an edge pulse never lasts more than one cycle
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);
endmodule

// File: rtl/rfc_control.sv
module rfc_control
  import rfc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             edgePulse,
  input  logic             armReq,
  input  logic             readyClr,
  input  logic             autoMode,
  input  logic             clearOnCapture,
  input  logic [CNT_W-1:0] cycleLimit,
  output rfcStrobe_t       strobe,
  output logic             ready
);
  logic             armed;
  logic [CNT_W-1:0] autoCnt;
  logic [CNT_W-1:0] limitEff;
  logic             windowEnd;
  logic             fire;

  assign limitEff  = (cycleLimit == '0) ? CNT_W'(1) : cycleLimit;
  assign windowEnd = (autoCnt >= limitEff - CNT_W'(1));
  assign fire      = edgePulse && !ready && (autoMode ? windowEnd : armed);

  always_ff @(posedge clk) begin
    if (!rstN)            armed <= 1'b0;
    else if (fire)        armed <= 1'b0;
    else if (armReq && !autoMode) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !autoMode) autoCnt <= '0;
    else if (edgePulse)     autoCnt <= windowEnd ? '0 : autoCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         ready <= 1'b0;
    else if (fire)     ready <= 1'b1;
    else if (readyClr) ready <= 1'b0;
  end

  always_comb begin
    strobe.capture     = fire;
    strobe.clearCounts = fire && clearOnCapture;
  end

  // R5: capture raises ready on the next cycle
  assert_capture_sets_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ready);
  // R5: ready only falls through readyClr
  assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !readyClr) |=> ready);
  // R4: a manual capture consumes the arm
  assert_one_shot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !autoMode) |=> !armed);
endmodule

// File: rtl/rfc_datapath.sv
module rfc_datapath
  import rfc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             edgePulse,
  input  logic [PRE_W-1:0] prescale,
  input  rfcStrobe_t       strobe,
  output logic [CNT_W-1:0] capTime,
  output logic [CNT_W-1:0] capCycles
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divEff;
  logic             tick;
  logic [CNT_W-1:0] timeCnt;
  logic [CNT_W-1:0] cycleCnt;

  assign divEff = (prescale < PRE_W'(2)) ? PRE_W'(1) : prescale;
  assign tick   = (preCnt >= divEff - PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearCounts) preCnt <= '0;
    else if (tick)                   preCnt <= '0;
    else                             preCnt <= preCnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearCounts) begin
      timeCnt  <= '0;
      cycleCnt <= '0;
    end else begin
      timeCnt  <= timeCnt + CNT_W'(tick);
      cycleCnt <= cycleCnt + CNT_W'(edgePulse);
    end
  end

  // The capture cycle's own tick and edge belong to this reading.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTime   <= '0;
      capCycles <= '0;
    end else if (strobe.capture) begin
      capTime   <= timeCnt + CNT_W'(tick);
      capCycles <= cycleCnt + CNT_W'(edgePulse);
    end
  end

  // R5: capture registers change only on a capture strobe
  assert_cap_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(capTime) && $stable(capCycles)));
  // R6: counters restart at zero after a clearing capture
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCounts |=> (timeCnt == '0 && cycleCnt == '0 && preCnt == '0));
  // R2: a capture always lands on an edge pulse, so a reading is never empty
  assert_capture_on_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> edgePulse);
endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter
  import rfc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] cycleLimit,
  input  logic             autoMode,
  input  logic             clearOnCapture,
  input  logic             armReq,
  input  logic             readyClr,
  output logic [CNT_W-1:0] capTime,
  output logic [CNT_W-1:0] capCycles,
  output logic             ready
);
  logic       edgePulse;
  rfcStrobe_t strobe;

  // One synchronizer shared by both counters
  rfc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .edgePulse(edgePulse));

  rfc_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .edgePulse(edgePulse), .armReq(armReq),
    .readyClr(readyClr), .autoMode(autoMode), .clearOnCapture(clearOnCapture),
    .cycleLimit(cycleLimit), .strobe(strobe), .ready(ready));

  rfc_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .edgePulse(edgePulse), .prescale(prescale),
    .strobe(strobe), .capTime(capTime), .capCycles(capCycles));
endmodule

// File: tb/recip_freq_counter_tb.sv
module recip_freq_counter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sigIn = 1'b0;
  logic [15:0] prescale = '0;
  logic [31:0] cycleLimit = '0;
  logic        autoMode = 1'b0, clearOnCapture = 1'b1;
  logic        armReq = 1'b0, readyClr = 1'b0;
  logic [31:0] capTime, capCycles;
  logic        ready;

  int  nRun = 0, nFail = 0;
  bit  done = 0;
  int  period = 0;   // 0 = input held low
  int  phase = 0;

  always #2 clk = ~clk;  // 250 MHz

  recip_freq_counter u_dut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .prescale(prescale),
    .cycleLimit(cycleLimit), .autoMode(autoMode), .clearOnCapture(clearOnCapture),
    .armReq(armReq), .readyClr(readyClr), .capTime(capTime),
    .capCycles(capCycles), .ready(ready));

  // Input generator, period in clocks, driven at the falling edge
  always @(negedge clk) begin
    if (period == 0) begin
      phase <= 0;
      sigIn <= 1'b0;
    end else begin
      sigIn <= (phase < period / 2);
      phase <= (phase + 1 >= period) ? 0 : phase + 1;
    end
  end

  // period, prescale, clearOnCapture
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{8, 1, 1}, '{12, 0, 1}, '{20, 3, 1}, '{9, 4, 1},
    '{16, 4, 0}, '{30, 5, 0}, '{10, 2, 0}};

  task automatic check(string tag, longint got, longint exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic waitReady(string tag);
    int n = 0;
    @(negedge clk);
    while (!ready && n < 3000) begin @(negedge clk); n++; end
    if (!ready) check({tag, " ready timeout"}, 0, 1);
  endtask

  task automatic pulse(bit clr, bit arm);
    readyClr = clr; armReq = arm;
    @(negedge clk);
    readyClr = 0; armReq = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nRun++; nFail++;
    $display("FAIL watchdog: got hung expected finish");
    finishRun();
  end

  initial begin
    longint t1, c1, k;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 ready after reset", ready, 0);
    check("R1 capTime after reset", capTime, 0);
    check("R1 capCycles after reset", capCycles, 0);

    // Vector table: prime, re-arm at once, compare
    for (int i = 0; i < NV; i++) begin
      int p, n, d;
      p = VEC[i][0]; n = VEC[i][1]; d = (n < 2) ? 1 : n;
      period = p; prescale = 16'(n); clearOnCapture = VEC[i][2][0];
      pulse(1, 1);
      waitReady("R4 prime");
      pulse(1, 1);
      waitReady("R4 rearm");
      if (VEC[i][2] != 0) begin
        check($sformatf("R6 R2 cycles v%0d", i), capCycles, 1);
        check($sformatf("R6 R3 time v%0d", i), capTime, p / d);
      end else begin
        t1 = capTime; c1 = capCycles;
        pulse(1, 1);
        waitReady("R7 second");
        check($sformatf("R7 R2 cycle diff v%0d", i), capCycles - c1, 1);
        check($sformatf("R7 R3 time diff v%0d", i), capTime - t1, p / d);
      end
    end

    // R4: no capture without a new arm
    period = 10; prescale = 1; clearOnCapture = 1;
    pulse(1, 1);
    waitReady("R4 setup");
    pulse(1, 0);
    repeat (50) @(negedge clk);
    check("R4 single shot, ready stays low", ready, 0);

    // R5: held reading, pending arm waits for clear
    pulse(0, 1);
    waitReady("R5 setup");
    pulse(1, 1);
    waitReady("R5 first");
    check("R5 first cycles", capCycles, 1);
    pulse(0, 1);
    repeat (55) @(negedge clk);
    check("R5 ready held", ready, 1);
    check("R5 capCycles held", capCycles, 1);
    check("R5 capTime held", capTime, 10);
    pulse(1, 0);
    waitReady("R5 after clear");
    k = capCycles;
    check("R5 R6 span covers held edges", (k >= 5), 1);
    check("R6 time equals cycles times period", capTime, k * 10);

    // R8: automatic windows of M edges
    autoMode = 1; cycleLimit = 4;
    pulse(1, 0);
    waitReady("R8 prime");
    pulse(1, 1);   // arm has no effect in this mode
    waitReady("R8 window");
    check("R8 cycles per window", capCycles, 4);
    check("R8 time per window", capTime, 40);
    repeat (120) @(negedge clk);
    check("R8 R5 held during dropped windows", capCycles, 4);
    pulse(1, 0);
    waitReady("R8 after drop");
    check("R8 dropped window whole multiple", (capCycles % 4 == 0) && (capCycles > 4), 1);
    check("R8 dropped window time", capTime, capCycles * 10);
    cycleLimit = 0;
    pulse(1, 0);
    waitReady("R8 M0 prime");
    pulse(1, 0);
    waitReady("R8 M0");
    check("R8 limit 0 means every edge", capCycles, 1);
    check("R8 limit 0 time", capTime, 10);

    // R8: in auto mode with input stopped, arm triggers nothing
    period = 0;
    pulse(1, 1);
    repeat (40) @(negedge clk);
    check("R8 R2 no edges, no capture", ready, 0);
    finishRun();
  end
endmodule